// File: doc/BRIEF.md
# Cascaded Display Sync Counter Bank

This block holds nine programmable timing counters that together build the timing strobes of a raster display: an internal line tick, horizontal and vertical sync, a line-active strobe and a pixel-active strobe. Each counter advances on a trigger it selects. The trigger is either the pixel tick or the strobe of another counter, so counters chain into line and frame timing. For example, a frame counter steps on the line counter's strobe.

The block runs on a core clock at twice the pixel rate. It makes its own pixel tick on every second core cycle and drives that tick out as the pixel clock. Each counter has a period, a start offset with its own trigger, a repeat limit and a clear trigger. An optional shaped pulse has rise and fall positions given in half-pixel units. Without the shaped pulse, the counter's output is a one-cycle strobe.

Software sets up the counters through a write-only register port. A global mask inverts individual outputs and the pixel clock.

Top module: `sync_counter_bank`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it is released until a counter is enabled, every counter is idle and `tmg_out` is all zero. `pclk_out` is low in reset and then toggles on every core cycle.
- R2: The trigger select code works as follows. 0 means never. 1 means the pixel tick, which fires on every second core cycle. A code n from 2 to 10 selects the strobe of counter n-1. A strobe is one core cycle wide and appears one cycle after the pulse that causes it, so each cascade level adds one cycle.
- R3: A running counter emits one pulse every `run_len`+1 ticks of its run trigger. Driven by the pixel tick, this gives a strobe period of 2·(`run_len`+1) core cycles.
- R4: After a counter starts or is cleared, its first pulse comes on the `ofs_len`-th tick of its offset trigger. If `ofs_len` is 0, the first pulse comes on the first run-trigger tick.
- R5: A repeat limit of 0 lets the counter run without end. A limit N>0 stops the counter after N pulses, and it stays stopped until its clear trigger fires.
- R6: A clear-trigger tick restarts the offset phase and zeroes the pulse tally. When a clear and a run trigger occur in the same cycle, the clear wins and no pulse is emitted.
- R7: With shaping enabled, the output is high while the core-cycle count since the last pulse, starting at 0 in the cycle after the pulse, lies in [`up`, `down`). This gives a period matching R3 and a width of `down`−`up` core cycles (half pixels).
- R8: Global word bit k-1 (k=1..8) inverts output k. Bit 8 inverts `pclk_out`. Output 9 has no invert bit. The mask takes effect on the cycle after the write.
- R9: Per-counter writes go to shadow storage. The counter takes them up while idle, on each of its own pulses, and on a clear. A period that is already running finishes with its old settings.
- R10: `wr_addr`[7:4] selects the target: 0 is the global word, and 1..9 select a counter. For a counter, `wr_addr`[3:0] selects the word:
  - Word 0 holds `run_len`[11:0], `run_src`[15:12], `ofs_len`[27:16] and `ofs_src`[31:28].
  - Word 1 holds `rep`[15:0], `clr_src`[19:16] and the shaping enable [20].
  - Word 2 holds `up`[9:0] and `down`[25:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address (target and word) |
| wr_data | input | 32 | Write data |
| tmg_out | output | 9 | Counter outputs after inversion, bit k-1 for counter k |
| pclk_out | output | 1 | Pixel clock after optional inversion |

## Verification
On every cycle, the assertions check the following:
- Reset silences every output.
- A strobe never lasts two cycles.
- The period and offset tallies stay inside their programmed limits.
- A stopped counter emits nothing.
- A clear leaves the counter in a fresh offset phase with a zero tally.
- A global write lands in the invert mask.

Only the bench scenarios can show the rest:
- The actual spacing of pulses over whole periods.
- The cascade lag between counters.
- The exact delay from a clear to the first offset pulse.
- The deferred take-up of a new period.
- The shape and inversion of a pulse as seen on the pins.

// File: rtl/scb_pkg.sv
package scb_pkg;
  parameter int RUN_W = 12;
  parameter int REP_W = 16;
  parameter int EDG_W = 10;
  parameter int SRC_W = 4;
  localparam int STB_N = 1 << SRC_W;

  typedef struct packed {
    logic [SRC_W-1:0] run_src;
    logic [RUN_W-1:0] run_len;
    logic [SRC_W-1:0] ofs_src;
    logic [RUN_W-1:0] ofs_len;
    logic [REP_W-1:0] rep;
    logic [SRC_W-1:0] clr_src;
    logic             pol_en;
    logic [EDG_W-1:0] up;
    logic [EDG_W-1:0] down;
  } cnt_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_OFS, ST_RUN, ST_DONE} cnt_st_t;

  // Trigger select: 0 never, 1 pixel tick, n>=2 strobe of counter n-1.
  function automatic logic pick_src(input logic [SRC_W-1:0] sel,
                                    input logic             pix,
                                    input logic [STB_N-1:0] stb);
    if (sel == '0) return 1'b0;
    if (sel == SRC_W'(1)) return pix;
    return stb[sel - SRC_W'(2)];
  endfunction

  // Shaped pulse level from elapsed half-pixel count.
  function automatic logic edge_level(input logic             vld,
                                      input logic [EDG_W-1:0] et,
                                      input logic [EDG_W-1:0] up,
                                      input logic [EDG_W-1:0] down);
    return vld && (et >= up) && (et < down);
  endfunction
endpackage

// File: rtl/scb_regs.sv
module scb_regs
  import scb_pkg::*;
#(
  parameter int NCNT = 9,
  parameter int NINV = 8,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  output cnt_cfg_t [NCNT-1:0]   shd,
  output logic [NINV-1:0]       inv,
  output logic                  clk_inv
);
  localparam int IDX_W = AW - 4;
  localparam int HALF  = DW / 2;

  logic [IDX_W-1:0] idx;
  logic [3:0]       word;
  logic             glb_wr;

  assign idx    = wr_addr[AW-1:4];
  assign word   = wr_addr[3:0];
  assign glb_wr = wr_en && (idx == '0) && (word == 4'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shd     <= '0;
      inv     <= '0;
      clk_inv <= 1'b0;
    end else if (wr_en) begin
      if (glb_wr) begin
        inv     <= wr_data[NINV-1:0];
        clk_inv <= wr_data[NINV];
      end
      for (int k = 0; k < NCNT; k++) begin
        if (idx == IDX_W'(k + 1)) begin
          case (word)
            4'd0: begin
              shd[k].run_len <= wr_data[RUN_W-1:0];
              shd[k].run_src <= wr_data[RUN_W +: SRC_W];
              shd[k].ofs_len <= wr_data[HALF +: RUN_W];
              shd[k].ofs_src <= wr_data[HALF+RUN_W +: SRC_W];
            end
            4'd1: begin
              shd[k].rep     <= wr_data[REP_W-1:0];
              shd[k].clr_src <= wr_data[HALF +: SRC_W];
              shd[k].pol_en  <= wr_data[HALF+SRC_W];
            end
            4'd2: begin
              shd[k].up      <= wr_data[EDG_W-1:0];
              shd[k].down    <= wr_data[HALF +: EDG_W];
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R10: a global write lands in the invert mask on the next cycle
  a_r10_global_mask: assert property (@(posedge clk) disable iff (rst)
    glb_wr |=> (inv == $past(wr_data[NINV-1:0])));
endmodule

// File: rtl/scb_counter.sv
module scb_counter
  import scb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cnt_cfg_t         shd,
  input  logic             pix,
  input  logic [STB_N-1:0] stb,
  output logic             fire,
  output logic             tick_q,
  output logic             raw
);
  cnt_cfg_t         act;
  cnt_st_t          st;
  logic [RUN_W-1:0] ofs_cnt;
  logic [RUN_W-1:0] run_cnt;
  logic [REP_W-1:0] rep_cnt;
  logic [EDG_W-1:0] et;
  logic             vld;

  // Named internal events
  logic run_t, ofs_t, clr, last_pulse;

  assign run_t      = pick_src(act.run_src, pix, stb);
  assign ofs_t      = pick_src(act.ofs_src, pix, stb);
  assign clr        = pick_src(act.clr_src, pix, stb);
  assign last_pulse = (act.rep != '0) && ((rep_cnt + REP_W'(1)) == act.rep);

  always_comb begin
    fire = 1'b0;
    case (st)
      ST_OFS: if (!clr) begin
        if (act.ofs_len == '0) fire = run_t;
        else fire = ofs_t && (ofs_cnt == act.ofs_len - RUN_W'(1));
      end
      ST_RUN: if (!clr) fire = run_t && (run_cnt == act.run_len);
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      act     <= '0;
      ofs_cnt <= '0;
      run_cnt <= '0;
      rep_cnt <= '0;
      tick_q  <= 1'b0;
      et      <= '0;
      vld     <= 1'b0;
    end else begin
      tick_q <= fire;
      if (fire) begin
        et  <= '0;
        vld <= 1'b1;
      end else if (et != '1) begin
        et <= et + EDG_W'(1);
      end
      if (st == ST_IDLE) begin
        act     <= shd;
        ofs_cnt <= '0;
        run_cnt <= '0;
        rep_cnt <= '0;
        if (shd.run_src != '0) st <= ST_OFS;
      end else if (clr) begin
        act     <= shd;
        ofs_cnt <= '0;
        run_cnt <= '0;
        rep_cnt <= '0;
        st      <= (shd.run_src != '0) ? ST_OFS : ST_IDLE;
      end else if (fire) begin
        act     <= shd;
        run_cnt <= '0;
        rep_cnt <= rep_cnt + REP_W'(1);
        if (shd.run_src == '0) st <= ST_IDLE;
        else if (last_pulse)   st <= ST_DONE;
        else                   st <= ST_RUN;
      end else begin
        if (st == ST_OFS && ofs_t && act.ofs_len != '0) ofs_cnt <= ofs_cnt + RUN_W'(1);
        if (st == ST_RUN && run_t) run_cnt <= run_cnt + RUN_W'(1);
      end
    end
  end

  assign raw = act.pol_en ? edge_level(vld, et, act.up, act.down) : tick_q;

  // R2: a strobe is a single core cycle wide
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
  // R3: the period tally never passes the programmed length
  a_r3_run_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (run_cnt <= act.run_len));
  // R4: the offset tally stays below the programmed offset
  a_r4_ofs_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFS && act.ofs_len != '0) |-> (ofs_cnt < act.ofs_len));
  // R5: a stopped counter emits nothing
  a_r5_done_silent: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |-> !fire);
  // R6: a clear restarts the offset phase with a zero tally
  a_r6_clear_restart: assert property (@(posedge clk) disable iff (rst)
    (clr && st != ST_IDLE && shd.run_src != '0) |=>
      (st == ST_OFS && rep_cnt == '0 && ofs_cnt == '0 && !tick_q));
endmodule

// File: rtl/sync_counter_bank.sv
module sync_counter_bank
  import scb_pkg::*;
#(
  parameter int NCNT = 9,
  parameter int NINV = 8,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [NCNT-1:0] tmg_out,
  output logic            pclk_out
);
  localparam int PAD = STB_N - NCNT;

  cnt_cfg_t [NCNT-1:0] shd;
  logic [NINV-1:0]     inv;
  logic                clk_inv;
  logic                pix_ph;
  logic [NCNT-1:0]     fire, tick_q, raw;
  logic [STB_N-1:0]    stb_all;

  scb_regs #(.NCNT(NCNT), .NINV(NINV), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .shd(shd), .inv(inv), .clk_inv(clk_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) pix_ph <= 1'b0;
    else     pix_ph <= ~pix_ph;
  end

  assign stb_all  = {{PAD{1'b0}}, tick_q};
  assign pclk_out = pix_ph ^ clk_inv;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    scb_counter u_cnt (
      .clk(clk), .rst(rst), .shd(shd[g]), .pix(pix_ph), .stb(stb_all),
      .fire(fire[g]), .tick_q(tick_q[g]), .raw(raw[g])
    );
    if (g < NINV) begin : g_inv
      assign tmg_out[g] = raw[g] ^ inv[g];
    end else begin : g_plain
      assign tmg_out[g] = raw[g];
    end
  end

  // R1: reset silences every counter output and parks the pixel phase
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (raw == '0 && !pix_ph && fire == '0));
endmodule

// File: tb/sync_counter_bank_bench.sv
`timescale 1ns/100ps
module sync_counter_bank_bench;
  localparam int NCNT = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [NCNT-1:0] tmg_out;
  logic            pclk_out;

  sync_counter_bank u_sync_counter_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmg_out(tmg_out), .pclk_out(pclk_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int rise_cnt[NCNT] = '{default: 0};
  int last_rise[NCNT] = '{default: 0};
  int fall_cnt[NCNT] = '{default: 0};
  int last_fall[NCNT] = '{default: 0};
  logic [NCNT-1:0] prev_o = '0;

  always @(negedge clk) begin
    for (int k = 0; k < NCNT; k++) begin
      if (tmg_out[k] && !prev_o[k]) begin rise_cnt[k]++; last_rise[k] = cyc; end
      if (!tmg_out[k] && prev_o[k]) begin fall_cnt[k]++; last_fall[k] = cyc; end
    end
    prev_o = tmg_out;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  // R10 layout: words 1 and 2 first, word 0 (holding the run trigger) last
  task automatic setc(input int k, input int rsrc, input int rlen, input int osrc,
                      input int olen, input int rep, input int csrc, input int pol,
                      input int up, input int down);
    wr({4'(k), 4'd1}, {11'd0, 1'(pol), 4'(csrc), 16'(rep)});
    wr({4'(k), 4'd2}, {6'd0, 10'(down), 6'd0, 10'(up)});
    wr({4'(k), 4'd0}, {4'(osrc), 12'(olen), 4'(rsrc), 12'(rlen)});
  endtask

  task automatic wait_rise(input int k, output int when);
    int c0 = rise_cnt[k];
    when = -1;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (rise_cnt[k] != c0) begin when = last_rise[k]; return; end
    end
  endtask

  task automatic wait_fall(input int k, output int when);
    int c0 = fall_cnt[k];
    when = -1;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (fall_cnt[k] != c0) begin when = last_fall[k]; return; end
    end
  endtask

  task automatic t_reset();
    int tog = 0;
    logic p;
    @(negedge clk); #1;
    chk("R1 outputs in reset", int'(tmg_out), 0);
    chk("R1 pclk low in reset", int'(pclk_out), 0);
    rst = 1'b0;
    p = pclk_out;
    for (int i = 0; i < 20; i++) begin
      step();
      if (tmg_out != '0) tog = -1000;
      if (pclk_out != p) tog++;
      p = pclk_out;
    end
    chk("R1 idle outputs quiet, pclk toggles each cycle", tog, 20);
  endtask

  task automatic t_period();
    int a, b, c;
    do_reset();
    setc(1, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    wait_rise(0, a);
    wait_rise(0, b);
    chk("R3 pixel-driven period", b - a, 10);
    step();
    chk("R2 strobe one cycle wide", int'(tmg_out[0]), 0);
    wait_rise(0, c);
    chk("R5 free run keeps pulsing", c - b, 10);
  endtask

  task automatic t_cascade();
    int x, y;
    do_reset();
    setc(1, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    setc(2, 2, 2, 0, 0, 0, 0, 0, 0, 0);
    wait_rise(1, x);
    chk("R2 cascade lag one cycle", x - last_rise[0], 1);
    wait_rise(1, y);
    chk("R3 cascaded period", y - x, 30);
  endtask

  task automatic t_wave();
    int a, f, b;
    do_reset();
    setc(3, 1, 9, 0, 0, 0, 0, 1, 2, 8);
    wait_rise(2, a);
    wait_fall(2, f);
    chk("R7 shaped width down-up", f - a, 6);
    wait_rise(2, b);
    chk("R7 shaped period", b - a, 20);
  endtask

  task automatic t_invert();
    int f, r, par;
    logic p0;
    wr(8'h00, 32'h004);
    wait_fall(2, f);
    wait_rise(2, r);
    chk("R8 inverted pulse low width", r - f, 6);
    wr(8'h00, 32'h0FF);
    chk("R8 idle counter 8 inverted", int'(tmg_out[7]), 1);
    chk("R8 counter 9 not invertible", int'(tmg_out[8]), 0);
    p0 = pclk_out;
    par = cyc % 2;
    wr(8'h00, 32'h1FF);
    while (cyc % 2 != par) step();
    chk("R8 pclk inverted", int'(pclk_out), int'(!p0));
  endtask

  task automatic t_repeat();
    int c0;
    do_reset();
    c0 = rise_cnt[3];
    setc(4, 1, 1, 0, 0, 3, 0, 0, 0, 0);
    repeat (100) step();
    chk("R5 repeat limit stops after N", rise_cnt[3] - c0, 3);
  endtask

  task automatic t_clear();
    int a, b, c, d, n;
    do_reset();
    setc(1, 1, 19, 0, 0, 0, 0, 0, 0, 0);
    setc(4, 1, 0, 1, 5, 2, 2, 0, 0, 0);
    wait_rise(0, a);
    wait_rise(0, a);
    wait_rise(3, b);
    chk("R4 offset after clear", b - a, 10);
    wait_rise(3, c);
    chk("R4 second pulse one tick later", c - a, 12);
    n = rise_cnt[3];
    wait_rise(0, d);
    repeat (14) step();
    chk("R6 clear resets repeat tally", rise_cnt[3] - n, 2);
  endtask

  task automatic t_prio();
    int n1, n5;
    do_reset();
    setc(1, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    setc(5, 2, 0, 0, 0, 0, 2, 0, 0, 0);
    n1 = rise_cnt[0];
    n5 = rise_cnt[4];
    repeat (200) step();
    chk("R6 clear beats simultaneous trigger", rise_cnt[4] - n5, 0);
    chk("R3 trigger counter kept running", rise_cnt[0] - n1, 20);
  endtask

  task automatic t_update();
    int a, b, c;
    do_reset();
    setc(1, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    wait_rise(0, a);
    wr(8'h10, {4'd0, 12'd0, 4'd1, 12'd9});
    wait_rise(0, b);
    chk("R9 running period keeps old length", b - a, 10);
    wait_rise(0, c);
    chk("R9 new length after boundary", c - b, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_cascade();
    t_wave();
    t_invert();
    t_repeat();
    t_clear();
    t_prio();
    t_update();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule